// File: doc/BRIEF.md
# Barker Code-Timing Acquisition Filter

This block finds the code timing of a direct-sequence signal spread by the 11-chip Barker code. Each accepted baseband sample, 4 bits signed at 4 samples per chip, enters a tapped delay line. On every accepted sample a pipelined matched filter adds the eleven taps that lie one chip apart. Each tap is added or subtracted according to its chip, so no multiplier is needed. The filter therefore produces one correlation value for every sample position.

Positions are counted modulo 44, one symbol. Across each 44-sample window the block keeps the position with the largest absolute correlation. At the end of the window it publishes that position and its magnitude, so the despreader can move its symbol boundary while reception continues. Because the magnitude is used, a symbol inverted by the data is found just as well.

An acquired flag reports a lock. It is set when the same position has won three windows in a row and the winning magnitude is above a threshold taken from an input.

Top module: `barker_acq`

## Requirements
- R1: While reset is asserted and until the first window completes, `win_strobe`, `peak_off`, `peak_mag` and `acquired` are all zero.
- R2: The correlation for a sample is the sum of eleven taps spaced 4 accepted samples apart. The newest tap is weighted by the last chip. The weights, from oldest to newest tap, are +1 +1 +1 -1 -1 -1 +1 -1 -1 +1 -1. A clean, aligned signal of chip amplitude A therefore yields a peak magnitude of 11*A.
- R3: `peak_off` is the window position (0 to 43) of the sample that completed the largest absolute correlation. Positions count accepted samples since reset, modulo 44.
- R4: A symbol with inverted polarity gives the same peak magnitude and offset as the non-inverted one.
- R5: When several positions share the largest magnitude, the earliest position in the window is reported. An all-zero input reports offset 0 and magnitude 0.
- R6: Each window is judged only on its own 44 samples. Results change only in the single cycle where `win_strobe` is high, and they hold their value between strobes.
- R7: A cycle with `smp_vld` low neither advances the delay line nor the position count, whatever value `smp_in` carries.
- R8: `acquired` goes high at a window end when that window's offset equals the offsets of the two windows before it and `peak_mag` is strictly greater than `thr`.
- R9: `acquired` goes low at the first window end where either condition of R8 fails.
- R10: `win_strobe` is high exactly in the cycle that starts two clock edges after the edge accepting a window's 44th sample. The new results are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Sample strobe; `smp_in` is taken on this cycle |
| smp_in | input | 4 | Signed baseband sample |
| thr | input | 9 | Lock threshold on the peak magnitude |
| win_strobe | output | 1 | One-cycle pulse when window results update |
| peak_off | output | 6 | Winning sample position within the window |
| peak_mag | output | 9 | Absolute correlation at the winning position |
| acquired | output | 1 | Code-timing lock indicator |

## Verification
The final comparison of a window and the restart of the running maximum fall in adjacent pipeline slots. The window-end latch and the lock decision fall in the very same cycle. Both are provoked by feeding samples back to back across window boundaries, with the correlation peak placed at position 0, right after a restart, and near the end of the window. They are judged by reading the published offset together with the acquired flag, and by counting the exact cycle of the strobe. Lock loss is provoked by changing the code delay mid-stream and observing the flag drop at the first clean window.

// File: rtl/barker_acq_pkg.sv
package barker_acq_pkg;
  localparam int CHIPS = 11;
  // chip 0 sits at the MSB; 1 means +1, 0 means -1
  localparam logic [CHIPS-1:0] BARKER = 11'b111_0001_0010;

  function automatic logic chip_plus(input int k);
    return BARKER[CHIPS-1-k];
  endfunction
endpackage

// File: rtl/bacq_tapline.sv
module bacq_tapline #(
  parameter int SAMPLE_W = 4,
  parameter int SPC      = 4,
  localparam int CHIPS   = barker_acq_pkg::CHIPS,
  localparam int WIN     = CHIPS * SPC,
  localparam int OFF_W   = $clog2(WIN),
  localparam int DEPTH   = (CHIPS - 1) * SPC + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_vld,
  input  logic signed [SAMPLE_W-1:0] in_smp,
  output logic signed [SAMPLE_W-1:0] tap_o [CHIPS],
  output logic [OFF_W-1:0]           pos_o,
  output logic                       vld_o
);
  logic signed [SAMPLE_W-1:0] line_q [DEPTH];
  logic signed [SAMPLE_W-1:0] line_d [DEPTH];
  logic [OFF_W-1:0] cnt_q, cnt_d, pos_q, pos_d;
  logic             vld_q;

  always_comb begin
    cnt_d = cnt_q;
    pos_d = pos_q;
    for (int i = 0; i < DEPTH; i++) line_d[i] = line_q[i];
    if (in_vld) begin
      line_d[0] = in_smp;
      for (int i = 1; i < DEPTH; i++) line_d[i] = line_q[i-1];
      pos_d = cnt_q;
      cnt_d = (cnt_q == OFF_W'(WIN - 1)) ? '0 : cnt_q + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
      cnt_q <= '0;
      pos_q <= '0;
      vld_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= line_d[i];
      cnt_q <= cnt_d;
      pos_q <= pos_d;
      vld_q <= in_vld;
    end
  end

  // newest sample lands on the last chip
  for (genvar k = 0; k < CHIPS; k++) begin : g_tap
    assign tap_o[k] = line_q[(CHIPS - 1 - k) * SPC];
  end

  assign pos_o = pos_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/bacq_corr.sv
module bacq_corr #(
  parameter int SAMPLE_W = 4,
  parameter int SPC      = 4,
  localparam int CHIPS   = barker_acq_pkg::CHIPS,
  localparam int WIN     = CHIPS * SPC,
  localparam int OFF_W   = $clog2(WIN),
  localparam int CORR_W  = SAMPLE_W + $clog2(CHIPS) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] tap_i [CHIPS],
  input  logic [OFF_W-1:0]           pos_i,
  input  logic                       vld_i,
  output logic signed [CORR_W-1:0]   corr_o,
  output logic [OFF_W-1:0]           pos_o,
  output logic                       vld_o
);
  logic signed [CORR_W-1:0] term [CHIPS];
  logic signed [CORR_W-1:0] sum;
  logic signed [CORR_W-1:0] corr_q, corr_d;
  logic [OFF_W-1:0]         pos_q, pos_d;
  logic                     vld_q;

  for (genvar k = 0; k < CHIPS; k++) begin : g_term
    logic signed [CORR_W-1:0] ext;
    assign ext     = {{(CORR_W - SAMPLE_W){tap_i[k][SAMPLE_W-1]}}, tap_i[k]};
    assign term[k] = barker_acq_pkg::chip_plus(k) ? ext : -ext;
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < CHIPS; k++) sum = sum + term[k];
    corr_d = vld_i ? sum   : corr_q;
    pos_d  = vld_i ? pos_i : pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0;
      pos_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      corr_q <= corr_d;
      pos_q  <= pos_d;
      vld_q  <= vld_i;
    end
  end

  assign corr_o = corr_q;
  assign pos_o  = pos_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/bacq_peak.sv
module bacq_peak #(
  parameter int SAMPLE_W = 4,
  parameter int SPC      = 4,
  localparam int CHIPS   = barker_acq_pkg::CHIPS,
  localparam int WIN     = CHIPS * SPC,
  localparam int OFF_W   = $clog2(WIN),
  localparam int CORR_W  = SAMPLE_W + $clog2(CHIPS) + 1,
  localparam int MAG_W   = CORR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [CORR_W-1:0] corr_i,
  input  logic [OFF_W-1:0]         pos_i,
  input  logic                     vld_i,
  output logic                     last_o,
  output logic [MAG_W-1:0]         mag_o,
  output logic [OFF_W-1:0]         off_o
);
  logic [MAG_W-1:0] mag, max_q, max_d;
  logic [OFF_W-1:0] arg_q, arg_d;
  logic             take;

  always_comb begin
    mag   = corr_i[CORR_W-1] ? MAG_W'(-corr_i) : MAG_W'(corr_i);
    // first position of a window reloads; later ones must beat strictly
    take  = (pos_i == '0) || (mag > max_q);
    max_d = max_q;
    arg_d = arg_q;
    if (vld_i && take) begin
      max_d = mag;
      arg_d = pos_i;
    end
    last_o = vld_i && (pos_i == OFF_W'(WIN - 1));
    mag_o  = take ? mag   : max_q;
    off_o  = take ? pos_i : arg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= '0;
      arg_q <= '0;
    end else begin
      max_q <= max_d;
      arg_q <= arg_d;
    end
  end
endmodule

// File: rtl/bacq_report.sv
module bacq_report #(
  parameter int SAMPLE_W  = 4,
  parameter int SPC       = 4,
  parameter int LOCK_WINS = 3,
  localparam int CHIPS    = barker_acq_pkg::CHIPS,
  localparam int WIN      = CHIPS * SPC,
  localparam int OFF_W    = $clog2(WIN),
  localparam int MAG_W    = SAMPLE_W + $clog2(CHIPS) + 1,
  localparam int STRK_W   = $clog2(LOCK_WINS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             last_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [MAG_W-1:0] thr,
  output logic             stb_o,
  output logic [OFF_W-1:0] off_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             acq_o
);
  logic [OFF_W-1:0]  off_q, off_d;
  logic [MAG_W-1:0]  mag_q, mag_d;
  logic [STRK_W-1:0] strk_q, strk_d, strk_nx;
  logic              acq_q, acq_d, stb_q;

  always_comb begin
    if (off_i != off_q)                     strk_nx = STRK_W'(1);
    else if (strk_q == STRK_W'(LOCK_WINS))  strk_nx = strk_q;
    else                                    strk_nx = strk_q + STRK_W'(1);
    off_d  = off_q;
    mag_d  = mag_q;
    strk_d = strk_q;
    acq_d  = acq_q;
    if (last_i) begin
      off_d  = off_i;
      mag_d  = mag_i;
      strk_d = strk_nx;
      acq_d  = (strk_nx >= STRK_W'(LOCK_WINS)) && (mag_i > thr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      mag_q  <= '0;
      strk_q <= '0;
      acq_q  <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      off_q  <= off_d;
      mag_q  <= mag_d;
      strk_q <= strk_d;
      acq_q  <= acq_d;
      stb_q  <= last_i;
    end
  end

  assign stb_o = stb_q;
  assign off_o = off_q;
  assign mag_o = mag_q;
  assign acq_o = acq_q;
endmodule

// File: rtl/barker_acq.sv
module barker_acq #(
  parameter int SAMPLE_W  = 4,
  parameter int SPC       = 4,
  parameter int LOCK_WINS = 3,
  localparam int CHIPS    = barker_acq_pkg::CHIPS,
  localparam int WIN      = CHIPS * SPC,
  localparam int OFF_W    = $clog2(WIN),
  localparam int CORR_W   = SAMPLE_W + $clog2(CHIPS) + 1,
  localparam int MAG_W    = CORR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_vld,
  input  logic signed [SAMPLE_W-1:0] smp_in,
  input  logic [MAG_W-1:0]           thr,
  output logic                       win_strobe,
  output logic [OFF_W-1:0]           peak_off,
  output logic [MAG_W-1:0]           peak_mag,
  output logic                       acquired
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic signed [SAMPLE_W-1:0] taps [CHIPS];
  logic [OFF_W-1:0]           a_pos, b_pos, w_off;
  logic                       a_vld, b_vld, w_last;
  logic signed [CORR_W-1:0]   b_corr;
  logic [MAG_W-1:0]           w_mag;

  bacq_tapline #(.SAMPLE_W(SAMPLE_W), .SPC(SPC)) u_line (
    .clk(clk), .rst_n(rst_sync), .in_vld(smp_vld), .in_smp(smp_in),
    .tap_o(taps), .pos_o(a_pos), .vld_o(a_vld));

  bacq_corr #(.SAMPLE_W(SAMPLE_W), .SPC(SPC)) u_corr (
    .clk(clk), .rst_n(rst_sync), .tap_i(taps), .pos_i(a_pos), .vld_i(a_vld),
    .corr_o(b_corr), .pos_o(b_pos), .vld_o(b_vld));

  bacq_peak #(.SAMPLE_W(SAMPLE_W), .SPC(SPC)) u_peak (
    .clk(clk), .rst_n(rst_sync), .corr_i(b_corr), .pos_i(b_pos), .vld_i(b_vld),
    .last_o(w_last), .mag_o(w_mag), .off_o(w_off));

  bacq_report #(.SAMPLE_W(SAMPLE_W), .SPC(SPC), .LOCK_WINS(LOCK_WINS)) u_rep (
    .clk(clk), .rst_n(rst_sync), .last_i(w_last), .mag_i(w_mag), .off_i(w_off),
    .thr(thr), .stb_o(win_strobe), .off_o(peak_off), .mag_o(peak_mag),
    .acq_o(acquired));
endmodule

// File: rtl/bacq_checker.sv
module bacq_checker #(
  parameter int SAMPLE_W  = 4,
  parameter int SPC       = 4,
  parameter int LOCK_WINS = 3,
  localparam int CHIPS    = barker_acq_pkg::CHIPS,
  localparam int WIN      = CHIPS * SPC,
  localparam int OFF_W    = $clog2(WIN),
  localparam int MAG_W    = SAMPLE_W + $clog2(CHIPS) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MAG_W-1:0] thr,
  input logic             win_strobe,
  input logic [OFF_W-1:0] peak_off,
  input logic [MAG_W-1:0] peak_mag,
  input logic             acquired
);
  // R6: strobe lasts one cycle
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_strobe |=> !win_strobe);

  // R6: results only move in a strobe cycle
  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_strobe |-> ($stable(peak_off) && $stable(peak_mag) && $stable(acquired)));

  // R3: offset stays inside the window
  p_off_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    peak_off < OFF_W'(WIN));

  // R2: magnitude never exceeds eleven full-scale chips
  p_mag_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    peak_mag <= MAG_W'(CHIPS * (1 << (SAMPLE_W - 1))));

  // R8: lock rises only with a repeated offset and a peak above threshold
  p_acq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acquired) |-> (win_strobe && $stable(peak_off) && (peak_mag > $past(thr))));

  // R9: lock falls only at a window end
  p_acq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acquired) |-> win_strobe);
endmodule

bind barker_acq bacq_checker #(.SAMPLE_W(SAMPLE_W), .SPC(SPC), .LOCK_WINS(LOCK_WINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .thr(thr), .win_strobe(win_strobe),
  .peak_off(peak_off), .peak_mag(peak_mag), .acquired(acquired));

// File: tb/sim_barker_acq.sv
module sim_barker_acq;
  localparam int CLK_PERIOD = 10;
  localparam int SW   = 4;
  localparam int OW   = 6;
  localparam int MW   = 9;
  localparam int WINL = 44;
  localparam int NV   = 8;
  localparam logic [10:0] BK = 11'b111_0001_0010;

  // per vector: code delay, chip amplitude, symbol polarity bits, threshold, gaps
  localparam int VD [NV] = '{0, 4, 17, 43, 43, 30, 2, 25};
  localparam int VA [NV] = '{7, 5, 3, 7, 7, 1, 0, 6};
  localparam int VB [NV] = '{255, 165, 60, 255, 255, 0, 255, 90};
  localparam int VT [NV] = '{50, 54, 40, 77, 76, 0, 0, 10};
  localparam int VG [NV] = '{0, 1, 0, 0, 0, 0, 0, 1};

  logic                 clk, rst_n, smp_vld;
  logic signed [SW-1:0] smp_in;
  logic [MW-1:0]        thr;
  logic                 win_strobe, acquired;
  logic [OW-1:0]        peak_off;
  logic [MW-1:0]        peak_mag;

  int n_chk = 0;
  int n_bad = 0;

  barker_acq u0 (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
    .thr(thr), .win_strobe(win_strobe), .peak_off(peak_off),
    .peak_mag(peak_mag), .acquired(acquired));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gen(input int n, input int d, input int a, input int bits);
    int m, sym, chip, c, s;
    m    = n - d + WINL;
    sym  = m / WINL;
    chip = (m % WINL) / 4;
    c    = BK[10 - chip] ? 1 : -1;
    s    = bits[sym] ? 1 : -1;
    return s * c * a;
  endfunction

  function automatic int exp_off(input int d);
    int best = WINL;
    for (int j = 0; j < 4; j++)
      if ((d + 40 + j) % WINL < best) best = (d + 40 + j) % WINL;
    return best;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_vld = 1'b0;
      smp_in  = 4'sb0111;  // junk while invalid
    end
  endtask

  task automatic feed(input int d, input int a, input int bits, input int gap,
                      input int first, input int last);
    for (int n = first; n <= last; n++) begin
      int v;
      v = gen(n, d, a, bits);
      @(negedge clk);
      smp_vld = 1'b1;
      smp_in  = v[SW-1:0];
      if (gap != 0 && n % 5 == 4) idle(1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    smp_vld = 1'b0;
    smp_in  = '0;
    thr     = '0;
    repeat (3) @(negedge clk);
    check("R1 strobe in reset", int'(win_strobe), 0);
    check("R1 offset in reset", int'(peak_off), 0);
    check("R1 magnitude in reset", int'(peak_mag), 0);
    check("R1 acquired in reset", int'(acquired), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 acquired after release", int'(acquired), 0);

    // table walk: four windows each, last three clean
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      thr = MW'(VT[i]);
      feed(VD[i], VA[i], VB[i], VG[i], 0, 4 * WINL - 1);
      idle(4);
      // R3 R4 R5 R7 offset, R2 magnitude, R8 lock
      check($sformatf("R3 offset vec%0d", i), int'(peak_off),
            (VA[i] == 0) ? 0 : exp_off(VD[i]));
      check($sformatf("R2 magnitude vec%0d", i), int'(peak_mag), 11 * VA[i]);
      check($sformatf("R8 acquired vec%0d", i), int'(acquired),
            (11 * VA[i] > VT[i]) ? 1 : 0);
    end

    // lock loss after a delay change, then hold and relock
    @(negedge clk);
    thr = MW'(10);
    feed(5, 6, 255, 0, 0, 2 * WINL - 1);
    idle(4);
    check("R9 acquired dropped", int'(acquired), 0);
    check("R3 offset after change", int'(peak_off), 1);
    feed(5, 6, 255, 0, 2 * WINL, 2 * WINL + 21);
    idle(2);
    check("R6 offset held mid window", int'(peak_off), 1);
    check("R6 magnitude held mid window", int'(peak_mag), 66);
    check("R6 acquired held mid window", int'(acquired), 0);
    feed(5, 6, 255, 0, 2 * WINL + 22, 4 * WINL - 1);
    idle(4);
    check("R8 relock", int'(acquired), 1);

    // strobe timing relative to the 44th sample
    feed(5, 6, 255, 0, 4 * WINL, 5 * WINL - 1);
    @(negedge clk);
    smp_vld = 1'b0;
    check("R10 strobe edge+1", int'(win_strobe), 0);
    @(negedge clk);
    check("R10 strobe edge+2 pending", int'(win_strobe), 0);
    @(negedge clk);
    check("R10 strobe cycle", int'(win_strobe), 1);
    check("R10 offset with strobe", int'(peak_off), 1);
    @(negedge clk);
    check("R10 strobe ends", int'(win_strobe), 0);
    check("R8 lock kept", int'(acquired), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule